// File: doc/BRIEF.md
# Memory-Side Request Arbiter for Misses, Writebacks and Prefetches

This block decides which request leaves a cache toward memory next. Three sources compete: a miss queue, a write buffer and a prefetch source. Each queue shows its oldest ready entry as an entry index, a block address and an order number. A single counter hands out order numbers across both queues, and each new allocation takes a larger one, so any miss can be compared in age with any writeback. Each queue also answers an address lookup. The lookup reports whether any pending entry, ready or not, sits on a given block, and gives that entry's index. The miss-queue lookup also gives the entry's order number.

Misses normally win. There is one exception: a full write buffer with nothing in service is treated as urgent, so its head write goes first. Even then, an older miss to the same block still goes ahead of it. When the write buffer is not full and a miss is chosen, any pending writeback to that miss's block is drained first, so the miss cannot fetch stale data. A prefetch runs only when neither queue is ready and the miss queue has room. The decision is registered and held until the consumer pulses accept.

Top module: `mem_req_arbiter`

## Requirements
- R1: After reset, and until an arbitration is made, `gnt_vld` is 0 and `gnt_src` is 0.
- R2: With only the miss queue ready and no write-buffer lookup hit, the miss head is granted: `gnt_src` = 3'b001, `gnt_idx` = `miss_idx`.
- R3: With only the write buffer ready, and the buffer not urgent, the write head is granted: `gnt_src` = 3'b010, `gnt_idx` = `wb_idx`.
- R4: With both queues ready, the miss head is granted when the write buffer is not full or has at least one entry in service, provided the write-buffer lookup does not hit.
- R5: The write buffer is urgent when `wb_full`=1 and `wb_insvc`=0. If it is urgent and has a ready entry, its head is granted, even when a miss is ready, unless R6 applies.
- R6: In the urgent case, if the miss-queue lookup hits with an order number strictly smaller than `wb_ord`, the matching miss entry (`mq_look_idx`) is granted with source 3'b001. An equal or larger order number leaves the write granted. This also applies when no miss is ready.
- R7: When a miss would be chosen and `wb_full`=0, a write-buffer lookup hit grants the matching writeback (`wb_look_idx`, source 3'b010, at the miss's block address) instead. While `wb_full`=1, the lookup hit is ignored.
- R8: With neither queue ready, a prefetch is granted (source 3'b100, index 0) only when `pf_vld`=1 and `miss_full`=0. Otherwise no grant is made.
- R9: A grant appears on the clock edge after its inputs are present. It holds all its fields while `accept`=0, even if the inputs change. It clears on the edge where `accept`=1 and re-arbitrates on the next edge.
- R10: Addresses are compared at block granularity: the low `OFFW` bits (6 by default) are zero in `mq_look_addr` (= `wb_addr` aligned), in `wb_look_addr` (= `miss_addr` aligned) and in `gnt_addr`.
- R11: Whenever `gnt_vld`=1, exactly one bit of `gnt_src` is set (bit 0 miss, bit 1 write buffer, bit 2 prefetch). Whenever `gnt_vld`=0, `gnt_src` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | Miss queue has a ready entry |
| miss_addr | input | AW | Address of the oldest ready miss |
| miss_ord | input | OW | Order number of the oldest ready miss |
| miss_idx | input | IW | Entry index of the oldest ready miss |
| miss_full | input | 1 | Miss queue has no free entry |
| wb_vld | input | 1 | Write buffer has a ready entry |
| wb_addr | input | AW | Address of the oldest ready write |
| wb_ord | input | OW | Order number of the oldest ready write |
| wb_idx | input | IW | Entry index of the oldest ready write |
| wb_full | input | 1 | Write buffer has no free entry |
| wb_insvc | input | CW | Count of write-buffer entries in service |
| pf_vld | input | 1 | Prefetch source has a request |
| pf_addr | input | AW | Prefetch address |
| mq_look_addr | output | AW | Block address looked up in the miss queue |
| mq_look_hit | input | 1 | A pending miss matches `mq_look_addr` |
| mq_look_ord | input | OW | Order number of that matching miss |
| mq_look_idx | input | IW | Entry index of that matching miss |
| wb_look_addr | output | AW | Block address looked up in the write buffer |
| wb_look_hit | input | 1 | A pending write matches `wb_look_addr` |
| wb_look_idx | input | IW | Entry index of that matching write |
| accept | input | 1 | Consumer takes the current grant |
| gnt_vld | output | 1 | A grant is being presented |
| gnt_src | output | 3 | One-hot source: bit 0 miss, bit 1 write, bit 2 prefetch |
| gnt_idx | output | IW | Granted entry index |
| gnt_addr | output | AW | Granted block address |

## Verification
A wrong priority choice shows at the ports one edge after the inputs settle, as a wrong `gnt_src` or `gnt_idx`. A mis-handled lookup shows the same way, as a head entry granted where a conflicting entry should have been, or the reverse, at the same point. A fault in the hold register shows either as fields that change while `accept` is low or as a grant that outlives its accept by one or more edges. A bad address mask appears immediately on the lookup outputs and on `gnt_addr` in the granting cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NSRC    = 3;
    localparam int SRC_MIS = 0;
    localparam int SRC_WRB = 1;
    localparam int SRC_PFT = 2;

    typedef enum logic [1:0] {
        PICK_NONE,
        PICK_MISS,
        PICK_WRITE,
        PICK_PREF
    } pick_e;

    function automatic logic [NSRC-1:0] pick_to_onehot(input pick_e p);
        logic [NSRC-1:0] oh;
        oh = '0;
        case (p)
            PICK_MISS:  oh[SRC_MIS] = 1'b1;
            PICK_WRITE: oh[SRC_WRB] = 1'b1;
            PICK_PREF:  oh[SRC_PFT] = 1'b1;
            default:    oh = '0;
        endcase
        return oh;
    endfunction
endpackage

// File: rtl/arb_select.sv
module arb_select
    import arb_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 6,
    parameter int OW   = 8,
    parameter int IW   = 3,
    parameter int CW   = 4
) (
    input  logic            miss_vld,
    input  logic [AW-1:0]   miss_addr,
    input  logic [IW-1:0]   miss_idx,
    input  logic            miss_full,
    input  logic            wb_vld,
    input  logic [AW-1:0]   wb_addr,
    input  logic [OW-1:0]   wb_ord,
    input  logic [IW-1:0]   wb_idx,
    input  logic            wb_full,
    input  logic [CW-1:0]   wb_insvc,
    input  logic            pf_vld,
    input  logic [AW-1:0]   pf_addr,
    input  logic            mq_look_hit,
    input  logic [OW-1:0]   mq_look_ord,
    input  logic [IW-1:0]   mq_look_idx,
    input  logic            wb_look_hit,
    input  logic [IW-1:0]   wb_look_idx,
    output logic [AW-1:0]   mq_look_addr,
    output logic [AW-1:0]   wb_look_addr,
    output logic            cand_vld,
    output logic [NSRC-1:0] cand_src,
    output logic [IW-1:0]   cand_idx,
    output logic [AW-1:0]   cand_addr
);
    localparam logic [AW-1:0] BLK_MASK = {{(AW-OFFW){1'b1}}, {OFFW{1'b0}}};

    logic  wb_urgent;
    logic  take_write_side;
    pick_e pick;

    always_comb begin
        mq_look_addr    = wb_addr & BLK_MASK;
        wb_look_addr    = miss_addr & BLK_MASK;
        wb_urgent       = wb_full && (wb_insvc == '0);
        take_write_side = wb_vld && (!miss_vld || wb_urgent);
        pick            = PICK_NONE;
        cand_idx        = '0;
        cand_addr       = '0;

        if (take_write_side) begin
            if (wb_urgent && mq_look_hit && (mq_look_ord < wb_ord)) begin
                // older miss on the same block leaves first
                pick      = PICK_MISS;
                cand_idx  = mq_look_idx;
                cand_addr = mq_look_addr;
            end else begin
                pick      = PICK_WRITE;
                cand_idx  = wb_idx;
                cand_addr = mq_look_addr;
            end
        end else if (miss_vld) begin
            if (!wb_full && wb_look_hit) begin
                // drain a pending write to the miss's block first
                pick      = PICK_WRITE;
                cand_idx  = wb_look_idx;
                cand_addr = wb_look_addr;
            end else begin
                pick      = PICK_MISS;
                cand_idx  = miss_idx;
                cand_addr = wb_look_addr;
            end
        end else if (pf_vld && !miss_full) begin
            pick      = PICK_PREF;
            cand_idx  = '0;
            cand_addr = pf_addr & BLK_MASK;
        end

        cand_vld = (pick != PICK_NONE);
        cand_src = pick_to_onehot(pick);
    end
endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
    import arb_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 6,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cand_vld,
    input  logic [NSRC-1:0] cand_src,
    input  logic [IW-1:0]   cand_idx,
    input  logic [AW-1:0]   cand_addr,
    input  logic            accept,
    output logic            gnt_vld,
    output logic [NSRC-1:0] gnt_src,
    output logic [IW-1:0]   gnt_idx,
    output logic [AW-1:0]   gnt_addr
);
    typedef struct packed {
        logic            vld;
        logic [NSRC-1:0] src;
        logic [IW-1:0]   idx;
        logic [AW-1:0]   addr;
    } gnt_t;

    gnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.vld) begin
            if (accept) begin
                st_d = '0;
            end
        end else if (cand_vld) begin
            st_d.vld  = 1'b1;
            st_d.src  = cand_src;
            st_d.idx  = cand_idx;
            st_d.addr = cand_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_vld  = st_q.vld;
    assign gnt_src  = st_q.src;
    assign gnt_idx  = st_q.idx;
    assign gnt_addr = st_q.addr;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && !accept) |=> (gnt_vld && $stable(gnt_src) && $stable(gnt_idx) && $stable(gnt_addr)));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && accept) |=> !gnt_vld);

    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld ? ($countones(gnt_src) == 1) : (gnt_src == '0));

    assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> (gnt_addr[OFFW-1:0] == '0));
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
    import arb_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 6,
    parameter int OW   = 8,
    parameter int IW   = 3,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_vld,
    input  logic [AW-1:0] miss_addr,
    input  logic [OW-1:0] miss_ord,
    input  logic [IW-1:0] miss_idx,
    input  logic          miss_full,
    input  logic          wb_vld,
    input  logic [AW-1:0] wb_addr,
    input  logic [OW-1:0] wb_ord,
    input  logic [IW-1:0] wb_idx,
    input  logic          wb_full,
    input  logic [CW-1:0] wb_insvc,
    input  logic          pf_vld,
    input  logic [AW-1:0] pf_addr,
    output logic [AW-1:0] mq_look_addr,
    input  logic          mq_look_hit,
    input  logic [OW-1:0] mq_look_ord,
    input  logic [IW-1:0] mq_look_idx,
    output logic [AW-1:0] wb_look_addr,
    input  logic          wb_look_hit,
    input  logic [IW-1:0] wb_look_idx,
    input  logic          accept,
    output logic          gnt_vld,
    output logic [2:0]    gnt_src,
    output logic [IW-1:0] gnt_idx,
    output logic [AW-1:0] gnt_addr
);
    logic            cand_vld;
    logic [NSRC-1:0] cand_src;
    logic [IW-1:0]   cand_idx;
    logic [AW-1:0]   cand_addr;
    logic            miss_ord_unused;

    // the head miss age only matters through the lookup path
    assign miss_ord_unused = ^miss_ord;

    arb_select #(.AW(AW), .OFFW(OFFW), .OW(OW), .IW(IW), .CW(CW)) u_select (
        .miss_vld     (miss_vld),
        .miss_addr    (miss_addr),
        .miss_idx     (miss_idx),
        .miss_full    (miss_full),
        .wb_vld       (wb_vld),
        .wb_addr      (wb_addr),
        .wb_ord       (wb_ord),
        .wb_idx       (wb_idx),
        .wb_full      (wb_full),
        .wb_insvc     (wb_insvc),
        .pf_vld       (pf_vld),
        .pf_addr      (pf_addr),
        .mq_look_hit  (mq_look_hit),
        .mq_look_ord  (mq_look_ord),
        .mq_look_idx  (mq_look_idx),
        .wb_look_hit  (wb_look_hit),
        .wb_look_idx  (wb_look_idx),
        .mq_look_addr (mq_look_addr),
        .wb_look_addr (wb_look_addr),
        .cand_vld     (cand_vld),
        .cand_src     (cand_src),
        .cand_idx     (cand_idx),
        .cand_addr    (cand_addr)
    );

    arb_grant_reg #(.AW(AW), .OFFW(OFFW), .IW(IW)) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_vld  (cand_vld),
        .cand_src  (cand_src),
        .cand_idx  (cand_idx),
        .cand_addr (cand_addr),
        .accept    (accept),
        .gnt_vld   (gnt_vld),
        .gnt_src   (gnt_src),
        .gnt_idx   (gnt_idx),
        .gnt_addr  (gnt_addr)
    );

    assert_pf_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gnt_vld) && gnt_src[SRC_PFT]) |-> $past(!miss_full && !miss_vld && !wb_vld));

    assert_older_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gnt_vld) && gnt_src[SRC_WRB] && $past(wb_full && (wb_insvc == '0) && wb_vld && mq_look_hit))
        |-> $past(mq_look_ord >= wb_ord));
endmodule

// File: tb/mem_req_arbiter_bench.sv
`timescale 1ns/1ps
module mem_req_arbiter_bench;
    localparam int AW = 32;
    localparam int OW = 8;
    localparam int IW = 3;
    localparam int CW = 4;
    localparam logic [AW-1:0] MSK = 32'hFFFF_FFC0;

    typedef struct packed {
        logic          mv;
        logic [AW-1:0] ma;
        logic [OW-1:0] mo;
        logic [IW-1:0] mi;
        logic          wv;
        logic [AW-1:0] wa;
        logic [OW-1:0] wo;
        logic [IW-1:0] wi;
        logic          wf;
        logic [CW-1:0] ins;
        logic          mf;
        logic          pv;
        logic [AW-1:0] pa;
        logic          qh;
        logic [OW-1:0] qo;
        logic [IW-1:0] qi;
        logic          bh;
        logic [IW-1:0] bi;
        logic [2:0]    es;
        logic [IW-1:0] ei;
        logic [AW-1:0] ea;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R2 miss only
        '{1'b1,32'h1044,8'd7,3'd2, 1'b0,32'h0,8'd0,3'd0, 1'b0,4'd0,1'b0, 1'b0,32'h0, 1'b0,8'd0,3'd0, 1'b0,3'd0, 3'b001,3'd2,32'h1040, 4'd2},
        // R3 write only
        '{1'b0,32'h0,8'd0,3'd0, 1'b1,32'h2010,8'd3,3'd5, 1'b0,4'd0,1'b0, 1'b0,32'h0, 1'b0,8'd0,3'd0, 1'b0,3'd0, 3'b010,3'd5,32'h2000, 4'd3},
        // R4 both ready, buffer not full
        '{1'b1,32'h3000,8'd4,3'd1, 1'b1,32'h4000,8'd2,3'd0, 1'b0,4'd0,1'b0, 1'b0,32'h0, 1'b0,8'd0,3'd0, 1'b0,3'd0, 3'b001,3'd1,32'h3000, 4'd4},
        // R4 full but entries in service
        '{1'b1,32'h3000,8'd4,3'd1, 1'b1,32'h4000,8'd2,3'd0, 1'b1,4'd2,1'b0, 1'b0,32'h0, 1'b0,8'd0,3'd0, 1'b0,3'd0, 3'b001,3'd1,32'h3000, 4'd4},
        // R5 urgent write beats miss
        '{1'b1,32'h3000,8'd4,3'd1, 1'b1,32'h4000,8'd2,3'd0, 1'b1,4'd0,1'b0, 1'b0,32'h0, 1'b0,8'd0,3'd0, 1'b0,3'd0, 3'b010,3'd0,32'h4000, 4'd5},
        // R6 older conflicting miss wins
        '{1'b1,32'h3000,8'd4,3'd1, 1'b1,32'h4000,8'd5,3'd0, 1'b1,4'd0,1'b0, 1'b0,32'h0, 1'b1,8'd1,3'd6, 1'b0,3'd0, 3'b001,3'd6,32'h4000, 4'd6},
        // R6 younger conflicting miss does not
        '{1'b1,32'h3000,8'd4,3'd1, 1'b1,32'h4000,8'd5,3'd0, 1'b1,4'd0,1'b0, 1'b0,32'h0, 1'b1,8'd9,3'd6, 1'b0,3'd0, 3'b010,3'd0,32'h4000, 4'd6},
        // R7 pending write to miss block drained first
        '{1'b1,32'h3000,8'd4,3'd1, 1'b1,32'h4000,8'd2,3'd0, 1'b0,4'd0,1'b0, 1'b0,32'h0, 1'b0,8'd0,3'd0, 1'b1,3'd3, 3'b010,3'd3,32'h3000, 4'd7},
        // R7 miss only, write lookup hit
        '{1'b1,32'h3abc,8'd4,3'd1, 1'b0,32'h0,8'd0,3'd0, 1'b0,4'd0,1'b0, 1'b0,32'h0, 1'b0,8'd0,3'd0, 1'b1,3'd4, 3'b010,3'd4,32'h3a80, 4'd7},
        // R7 lookup ignored while buffer full
        '{1'b1,32'h3000,8'd4,3'd1, 1'b1,32'h4000,8'd2,3'd0, 1'b1,4'd1,1'b0, 1'b0,32'h0, 1'b0,8'd0,3'd0, 1'b1,3'd3, 3'b001,3'd1,32'h3000, 4'd7},
        // R8 prefetch with room
        '{1'b0,32'h0,8'd0,3'd0, 1'b0,32'h0,8'd0,3'd0, 1'b0,4'd0,1'b0, 1'b1,32'h5005, 1'b0,8'd0,3'd0, 1'b0,3'd0, 3'b100,3'd0,32'h5000, 4'd8},
        // R8 prefetch blocked by full miss queue
        '{1'b0,32'h0,8'd0,3'd0, 1'b0,32'h0,8'd0,3'd0, 1'b0,4'd0,1'b1, 1'b1,32'h5005, 1'b0,8'd0,3'd0, 1'b0,3'd0, 3'b000,3'd0,32'h0, 4'd8},
        // R8 nothing at all
        '{1'b0,32'h0,8'd0,3'd0, 1'b0,32'h0,8'd0,3'd0, 1'b0,4'd0,1'b0, 1'b0,32'h0, 1'b0,8'd0,3'd0, 1'b0,3'd0, 3'b000,3'd0,32'h0, 4'd8},
        // R6 urgent write alone, older conflicting miss
        '{1'b0,32'h0,8'd0,3'd0, 1'b1,32'h4000,8'd5,3'd0, 1'b1,4'd0,1'b0, 1'b0,32'h0, 1'b1,8'd2,3'd7, 1'b0,3'd0, 3'b001,3'd7,32'h4000, 4'd6}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          miss_vld, miss_full, wb_vld, wb_full, pf_vld;
    logic [AW-1:0] miss_addr, wb_addr, pf_addr;
    logic [OW-1:0] miss_ord, wb_ord, mq_look_ord;
    logic [IW-1:0] miss_idx, wb_idx, mq_look_idx, wb_look_idx;
    logic [CW-1:0] wb_insvc;
    logic          mq_look_hit, wb_look_hit, accept;
    logic [AW-1:0] mq_look_addr, wb_look_addr, gnt_addr;
    logic          gnt_vld;
    logic [2:0]    gnt_src;
    logic [IW-1:0] gnt_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mem_req_arbiter u_mem_req_arbiter (
        .clk(clk), .rst_n(rst_n),
        .miss_vld(miss_vld), .miss_addr(miss_addr), .miss_ord(miss_ord), .miss_idx(miss_idx),
        .miss_full(miss_full),
        .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_ord(wb_ord), .wb_idx(wb_idx),
        .wb_full(wb_full), .wb_insvc(wb_insvc),
        .pf_vld(pf_vld), .pf_addr(pf_addr),
        .mq_look_addr(mq_look_addr), .mq_look_hit(mq_look_hit), .mq_look_ord(mq_look_ord),
        .mq_look_idx(mq_look_idx),
        .wb_look_addr(wb_look_addr), .wb_look_hit(wb_look_hit), .wb_look_idx(wb_look_idx),
        .accept(accept),
        .gnt_vld(gnt_vld), .gnt_src(gnt_src), .gnt_idx(gnt_idx), .gnt_addr(gnt_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        miss_vld = v.mv; miss_addr = v.ma; miss_ord = v.mo; miss_idx = v.mi;
        wb_vld = v.wv; wb_addr = v.wa; wb_ord = v.wo; wb_idx = v.wi;
        wb_full = v.wf; wb_insvc = v.ins; miss_full = v.mf;
        pf_vld = v.pv; pf_addr = v.pa;
        mq_look_hit = v.qh; mq_look_ord = v.qo; mq_look_idx = v.qi;
        wb_look_hit = v.bh; wb_look_idx = v.bi;
    endtask

    task automatic check_grant(input string req, input vec_t v);
        check(req, "gnt_vld", {31'd0, gnt_vld}, {31'd0, (v.es != 3'b000)});
        check(req, "gnt_src", {29'd0, gnt_src}, {29'd0, v.es});
        if (v.es != 3'b000) begin
            check(req, "gnt_idx", {29'd0, gnt_idx}, {29'd0, v.ei});
            check(req, "gnt_addr", gnt_addr, v.ea);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        accept = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        // R1 / R11: held in reset with a candidate present
        check("R1", "gnt_vld in reset", {31'd0, gnt_vld}, 32'd0);
        check("R11", "gnt_src in reset", {29'd0, gnt_src}, 32'd0);
        drive(VECS[12]);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "gnt_vld after reset", {31'd0, gnt_vld}, 32'd0);

        // table walk: each row checks grant, lookup addresses and release
        for (int k = 0; k < NV; k++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[k].rq);
            drive(VECS[k]);
            @(negedge clk);
            check_grant(rq, VECS[k]);
            check("R10", "mq_look_addr", mq_look_addr, VECS[k].wa & MSK);
            check("R10", "wb_look_addr", wb_look_addr, VECS[k].ma & MSK);
            if (VECS[k].es != 3'b000) begin
                accept = 1'b1;
                @(negedge clk);
                accept = 1'b0;
                check("R9", "cleared after accept", {31'd0, gnt_vld}, 32'd0);
            end
        end

        // R9 hold: grant stays while inputs change and accept is low
        drive(VECS[0]);
        @(negedge clk);
        check_grant("R9", VECS[0]);
        drive(VECS[1]);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check_grant("R9", VECS[0]);
        end
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        check("R9", "released", {31'd0, gnt_vld}, 32'd0);
        @(negedge clk);
        check_grant("R9", VECS[1]);
        check("R11", "one-hot", {31'd0, ($countones(gnt_src) == 1)}, 32'd1);
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        drive(VECS[12]);
        @(negedge clk);
        check("R9", "idle after last accept", {31'd0, gnt_vld}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule